// File: doc/BRIEF.md
# Single-Carrier Staircase PWM Modulator for a Three-Cell Unequal-Supply Bridge

This block produces the twelve switch gates of a single-phase stack of three H-bridge cells. The cells' DC supplies stand in the ratio 9:3:1, so the stack can place any integer multiple of the smallest supply, from -13 to +13, on the load. That gives 27 distinct output levels.

A phase accumulator advances once per carrier period and addresses a quarter-wave sine table. The magnitude of the sine is scaled by an amplitude word and split into an integer level and a fractional residue. One triangular carrier is compared with that residue. For each clock the comparison chooses either the integer level or the level one step above it, so the average over a carrier period tracks the reference. The chosen magnitude is split into one state per cell in {-1, 0, +1}, with the 9:3:1 weights. In the negative half of the fundamental every cell state is inverted. A smaller amplitude word uses fewer levels, down to 7 levels. The amplitude word is taken only at a carrier-period start, so a change never cuts into a period already in progress.

Top module: `staircase_pwm`

## Requirements
- R1: While `rst_n` is low, all twelve gates are 0. On the first clock after release, the gates show the zero level, `12'hAAA`.
- R2: Cell c (c = 0, 1, 2) owns gate bits [4c+3:4c], laid out as {B_low, B_high, A_low, A_high}. The state +1 is `4'b1001`, the state -1 is `4'b0110` and the state 0 is `4'b1010`. No other pattern occurs outside reset, and no leg ever has its high and low switch on together.
- R3: Cells 0, 1 and 2 carry weights 9, 3 and 1. The output level is the weighted sum of the cell states, and its magnitude never exceeds 13.
- R4: The carrier period is 2048 clocks. The carrier counts up from 0 to 1023 and back down. Period k after reset uses phase p = k·`phase_step` mod 65536, truncated to its upper 12 bits. It also uses the amplitude word A captured at that period's start. Period 0 uses A = 0. The reference is 13·(A/256)·sin(2π·p/65536).
- R5: The mean output level over each carrier period equals the R4 reference to within 0.05 of a level.
- R6: Within one carrier period, the output takes at most two adjacent levels. Every sample lies within 1.05 levels of the reference.
- R7: When phase bit 15 is set, every output level is zero or negative. When it is clear, every output level is zero or positive.
- R8: A change of `amplitude` in the middle of a carrier period has no effect on that period. It takes effect from the next period.
- R9: Amplitude 255 reaches levels +13 and -13 (27 levels in use). Amplitude 59 peaks at ±3 (7 levels). Amplitude 0 holds the zero level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_step | input | 16 | Phase advance applied once per carrier period |
| amplitude | input | 8 | Modulation depth, full scale 256 |
| gates | output | 12 | Registered switch commands, four per cell |

## Verification
The bench rebuilds the signed level from the gate pattern on every clock. It averages the level over each carrier period and compares the average with a reference computed in real arithmetic. A wrong weight, a sign slip in one cell's digit, or a missing inversion in the negative half shows up as a mean far off the reference or as a wrong polarity. A residue compared the wrong way, or an off-by-one level step, breaks the two-adjacent-levels rule or shifts the mean by whole fractions of a level. Three further tests cover the amplitude path. An amplitude change inside a period must leave that period's mean untouched. Low amplitude must stop at ±3. Full amplitude must reach ±13 without crossing it. A design that latched amplitude every clock would fail the first, and an overflowing scaler would fail the last.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

  // 3**e, used to size the level range from the cell count
  function automatic int pow3(input int e);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = r * 3;
    return r;
  endfunction

  // largest level magnitude reachable by CELLS cells weighted 1,3,9,...
  function automatic int max_level(input int cells);
    return (pow3(cells) - 1) / 2;
  endfunction

  // balanced-ternary digit of magnitude mag at position pos (pos 0 = weight 1)
  function automatic int ternary_digit(input int mag, input int pos);
    int rest;
    int d;
    rest = mag;
    d = 0;
    for (int p = 0; p <= pos; p++) begin
      case (rest % 3)
        0: begin d = 0;  rest = rest / 3;       end
        1: begin d = 1;  rest = (rest - 1) / 3; end
        default: begin d = -1; rest = (rest + 1) / 3; end
      endcase
    end
    return d;
  endfunction

  // gate nibble {B_low, B_high, A_low, A_high} for one cell state
  function automatic logic [3:0] cell_pattern(input int d);
    if (d > 0)      return 4'b1001;
    else if (d < 0) return 4'b0110;
    else            return 4'b1010;
  endfunction

endpackage

// File: rtl/mlpwm_sine_rom.sv
module mlpwm_sine_rom #(
  parameter int PHASE_W = 16,
  parameter int SINE_W  = 16,
  parameter int TBL_W   = 10
) (
  input  logic [PHASE_W-1:0] phase,
  output logic [SINE_W-1:0]  sine_mag
);
  localparam int ENTRIES = (1 << TBL_W) + 1;

  // rational sine approximation over a half wave, evaluated at elaboration
  function automatic longint sine_point(input longint i);
    longint n;
    longint u;
    longint num;
    longint den;
    n   = longint'(1) << (TBL_W + 1);
    u   = i * (n - i);
    num = ((longint'(1) << SINE_W) - 1) * 16 * u;
    den = 5 * n * n - 4 * u;
    return (num + den / 2) / den;
  endfunction

  logic [SINE_W-1:0] quarter [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_tbl
    assign quarter[i] = SINE_W'(sine_point(longint'(i)));
  end

  logic             mirror;
  logic [TBL_W-1:0] offset;
  logic [TBL_W:0]   index;

  assign mirror   = phase[PHASE_W-2];
  assign offset   = phase[PHASE_W-3 -: TBL_W];
  assign index    = mirror ? ((TBL_W+1)'(1 << TBL_W) - {1'b0, offset}) : {1'b0, offset};
  assign sine_mag = quarter[index];

endmodule

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier #(
  parameter int CAR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CAR_W-1:0] carrier,
  output logic             period_end
);
  logic [CAR_W:0] tick;

  always_ff @(posedge clk) begin
    if (!rst_n) tick <= '0;
    else        tick <= tick + 1'b1;
  end

  // rising half counts up, falling half mirrors it back down
  assign carrier    = tick[CAR_W] ? ~tick[CAR_W-1:0] : tick[CAR_W-1:0];
  assign period_end = &tick;

endmodule

// File: rtl/mlpwm_level_decoder.sv
module mlpwm_level_decoder
  import mlpwm_pkg::*;
#(
  parameter int CELLS = 3,
  parameter int MAG_W = 4
) (
  input  logic [MAG_W-1:0]   level_mag,
  input  logic               negative,
  output logic [4*CELLS-1:0] gates_next
);
  localparam int MAX_LEVEL = max_level(CELLS);

  logic [4*CELLS-1:0] pos_pat [MAX_LEVEL+1];
  logic [4*CELLS-1:0] neg_pat [MAX_LEVEL+1];

  // cell 0 is the heaviest cell, so its ternary position is CELLS-1
  for (genvar m = 0; m <= MAX_LEVEL; m++) begin : g_lvl
    for (genvar k = 0; k < CELLS; k++) begin : g_cell
      assign pos_pat[m][4*k +: 4] = cell_pattern(ternary_digit(m, CELLS - 1 - k));
      assign neg_pat[m][4*k +: 4] = cell_pattern(-ternary_digit(m, CELLS - 1 - k));
    end
  end

  logic [MAG_W-1:0] sel;

  always_comb begin
    sel = (int'(level_mag) > MAX_LEVEL) ? MAG_W'(MAX_LEVEL) : level_mag;
    gates_next = negative ? neg_pat[sel] : pos_pat[sel];
  end

endmodule

// File: rtl/staircase_pwm.sv
module staircase_pwm
  import mlpwm_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 8,
  parameter int SINE_W  = 16,
  parameter int TBL_W   = 10,
  parameter int CAR_W   = 10,
  parameter int CELLS   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase_step,
  input  logic [AMP_W-1:0]   amplitude,
  output logic [4*CELLS-1:0] gates
);
  localparam int MAX_LEVEL = max_level(CELLS);
  localparam int MAG_W     = $clog2(MAX_LEVEL + 1);
  localparam int FRAC_W    = SINE_W + AMP_W;
  localparam int PROD_W    = FRAC_W + MAG_W;

  // reference magnitude in units of one level, FRAC_W fractional bits
  function automatic logic [PROD_W-1:0] scale_ref(input logic [SINE_W-1:0] s,
                                                  input logic [AMP_W-1:0]  a);
    return PROD_W'(s) * PROD_W'(a) * PROD_W'(MAX_LEVEL);
  endfunction

  // named internal events, watched by the bound checker
  logic [CAR_W-1:0]   carrier;
  logic               period_end;
  logic [PHASE_W-1:0] phase_q;
  logic [AMP_W-1:0]   amp_q;
  logic [SINE_W-1:0]  sine_mag;
  logic [PROD_W-1:0]  ref_scaled;
  logic [MAG_W-1:0]   base_level;
  logic [CAR_W-1:0]   residue;
  logic               step_up;
  logic [MAG_W-1:0]   level_mag;
  logic               half_neg;
  logic [4*CELLS-1:0] gates_next;

  mlpwm_carrier #(.CAR_W(CAR_W)) u_carrier (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier    (carrier),
    .period_end (period_end)
  );

  // phase and amplitude move only at a carrier-period boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      amp_q   <= '0;
    end else if (period_end) begin
      phase_q <= phase_q + phase_step;
      amp_q   <= amplitude;
    end
  end

  mlpwm_sine_rom #(.PHASE_W(PHASE_W), .SINE_W(SINE_W), .TBL_W(TBL_W)) u_rom (
    .phase    (phase_q),
    .sine_mag (sine_mag)
  );

  assign ref_scaled = scale_ref(sine_mag, amp_q);
  assign base_level = ref_scaled[PROD_W-1 -: MAG_W];
  assign residue    = ref_scaled[FRAC_W-1 -: CAR_W];
  assign step_up    = residue > carrier;
  assign level_mag  = base_level + MAG_W'(step_up);
  assign half_neg   = phase_q[PHASE_W-1];

  mlpwm_level_decoder #(.CELLS(CELLS), .MAG_W(MAG_W)) u_dec (
    .level_mag  (level_mag),
    .negative   (half_neg),
    .gates_next (gates_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) gates <= '0;
    else        gates <= gates_next;
  end

endmodule

// File: rtl/staircase_pwm_props.sv
module staircase_pwm_props
  import mlpwm_pkg::*;
#(
  parameter int CELLS = 3,
  parameter int AMP_W = 8,
  parameter int MAG_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [4*CELLS-1:0] gates,
  input logic               period_end,
  input logic [AMP_W-1:0]   amp_q,
  input logic [MAG_W-1:0]   level_mag,
  input logic [MAG_W-1:0]   base_level
);
  localparam int MAX_LEVEL = max_level(CELLS);

  for (genvar k = 0; k < CELLS; k++) begin : g_leg
    assert_leg_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(gates[4*k] && gates[4*k+1]) && !(gates[4*k+2] && gates[4*k+3]));
  end

  assert_two_on_per_cell_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($countones(gates) == 2 * CELLS));

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level_mag) <= MAX_LEVEL);

  assert_adjacent_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mag >= base_level) && ((level_mag - base_level) <= MAG_W'(1)));

  assert_amp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(amp_q));

endmodule

bind staircase_pwm staircase_pwm_props #(
  .CELLS (CELLS),
  .AMP_W (AMP_W),
  .MAG_W (MAG_W)
) u_props (
  .clk        (clk),
  .rst_n      (rst_n),
  .gates      (gates),
  .period_end (period_end),
  .amp_q      (amp_q),
  .level_mag  (level_mag),
  .base_level (base_level)
);

// File: tb/staircase_pwm_test.sv
module staircase_pwm_test;
  localparam int  WIN = 2048;
  localparam real PI  = 3.14159265358979;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] phase_step = '0;
  logic [7:0]  amplitude = '0;
  logic [11:0] gates;

  int checks = 0;
  int errors = 0;
  int peak_pos;
  int peak_neg;

  staircase_pwm uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_step (phase_step),
    .amplitude  (amplitude),
    .gates      (gates)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%s expected=%s", req, what, act, exp);
    end
  endtask

  // signed level from gate nibbles; returns 0 on an illegal nibble (R2, R3)
  function automatic bit decode(input logic [11:0] g, output int lvl);
    bit ok;
    ok = 1'b1;
    lvl = 0;
    for (int c = 0; c < 3; c++) begin
      int w;
      w = (c == 0) ? 9 : (c == 1) ? 3 : 1;
      case (g[4*c +: 4])
        4'b1001: lvl += w;
        4'b0110: lvl -= w;
        4'b1010: ;
        default: ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

  function automatic real reference(input int unsigned ph, input int amp);
    int unsigned pq;
    pq = ph & 32'h0000FFF0;
    return 13.0 * (real'(amp) / 256.0) * (65535.0 / 65536.0) * $sin(2.0 * PI * real'(pq) / 65536.0);
  endfunction

  function automatic real rabs(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  task automatic apply_reset(input int amp, input int step);
    rst_n = 1'b0;
    amplitude = amp[7:0];
    phase_step = step[15:0];
    peak_pos = 0;
    peak_neg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one carrier period: k is the period index since reset
  task automatic measure_window(input int k, input int amp_exp, input int step,
                                input int change_at, input int new_amp, input string tag);
    int unsigned ph;
    real r;
    real mean;
    int sum, lo, hi, lvl;
    bit valid, bound_ok, sign_ok, near_ok;
    ph = (int'(k) * step) % 65536;
    r = reference(ph, amp_exp);
    sum = 0; lo = 99; hi = -99;
    valid = 1'b1; bound_ok = 1'b1; sign_ok = 1'b1; near_ok = 1'b1;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (i == change_at) amplitude = new_amp[7:0];
      if (!decode(gates, lvl)) valid = 1'b0;
      sum += lvl;
      if (lvl < lo) lo = lvl;
      if (lvl > hi) hi = lvl;
      if (lvl > peak_pos) peak_pos = lvl;
      if (lvl < peak_neg) peak_neg = lvl;
      if (lvl > 13 || lvl < -13) bound_ok = 1'b0;
      if ((ph >= 32768 && lvl > 0) || (ph < 32768 && lvl < 0)) sign_ok = 1'b0;
      if (rabs(real'(lvl) - r) > 1.05) near_ok = 1'b0;
    end
    mean = real'(sum) / real'(WIN);
    check(valid, "R2", $sformatf("legal cell patterns, period %0d", k),
          valid ? "legal" : "illegal", "legal");
    check(bound_ok, "R3", $sformatf("|level|<=13, period %0d", k),
          $sformatf("%0d..%0d", lo, hi), "-13..13");
    check(rabs(mean - r) <= 0.05, tag, $sformatf("mean vs R4 reference, period %0d", k),
          $sformatf("%f", mean), $sformatf("%f", r));
    check(hi - lo <= 1, "R6", $sformatf("two adjacent levels, period %0d", k),
          $sformatf("%0d..%0d", lo, hi), "spread<=1");
    check(near_ok, "R6", $sformatf("every sample within 1.05 of reference, period %0d", k),
          $sformatf("%0d..%0d", lo, hi), $sformatf("%f", r));
    check(sign_ok, "R7", $sformatf("polarity, period %0d phase %0d", k, ph),
          $sformatf("%0d..%0d", lo, hi), (ph >= 32768) ? "<=0" : ">=0");
  endtask

  task automatic test_reset;
    apply_reset(200, 1000);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(gates == 12'h000, "R1", "gates during reset",
          $sformatf("%h", gates), "000");
    rst_n = 1'b1;
    @(negedge clk);
    check(gates == 12'hAAA, "R1", "first cycle after reset",
          $sformatf("%h", gates), "aaa");
  endtask

  task automatic test_full_amplitude;
    apply_reset(255, 3277);
    for (int k = 0; k <= 20; k++)
      measure_window(k, (k == 0) ? 0 : 255, 3277, -1, 0, "R5");
    check(peak_pos == 13, "R9", "full amplitude positive peak",
          $sformatf("%0d", peak_pos), "13");
    check(peak_neg == -13, "R9", "full amplitude negative peak",
          $sformatf("%0d", peak_neg), "-13");
  endtask

  task automatic test_low_amplitude;
    apply_reset(59, 6554);
    for (int k = 0; k <= 10; k++)
      measure_window(k, (k == 0) ? 0 : 59, 6554, -1, 0, "R5");
    check(peak_pos == 3, "R9", "seven-level positive peak",
          $sformatf("%0d", peak_pos), "3");
    check(peak_neg == -3, "R9", "seven-level negative peak",
          $sformatf("%0d", peak_neg), "-3");
  endtask

  task automatic test_zero_amplitude;
    apply_reset(0, 3277);
    for (int k = 0; k < 4; k++)
      measure_window(k, 0, 3277, -1, 0, "R9");
    check(peak_pos == 0 && peak_neg == 0, "R9", "zero amplitude holds level 0",
          $sformatf("%0d/%0d", peak_neg, peak_pos), "0/0");
  endtask

  task automatic test_amplitude_change;
    apply_reset(255, 3277);
    measure_window(0, 0, 3277, -1, 0, "R8");
    measure_window(1, 255, 3277, 1000, 100, "R8");
    measure_window(2, 100, 3277, -1, 0, "R8");
    measure_window(3, 100, 3277, -1, 0, "R8");
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_full_amplitude();
    test_low_amplitude();
    test_zero_amplitude();
    test_amplitude_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule